// File: doc/BRIEF.md
# Power-up Mode Selection Sequencer

This block brings a converter-style device out of reset and decides how it will be controlled afterwards. Once the active-low reset is released, the device sits in a low-power selection state. During this state the filter reference stays off, and a fixed-length timed window runs. A single magic write inside that window puts the device under register control. If the window closes without that write, the device falls back to stand-alone hardware operation and starts normal operation at once. A later write that sets the control-port enable bit can still move it from hardware mode to register control.

In register-controlled mode the power-down bit in the control register governs power. Software loads the other settings while the bit is 1. When it clears the bit, a short power-up delay starts, and the ready flag rises at the end of that delay. The filter-reference enable follows the ready flag in both modes. Both intervals are computed from the clock-frequency parameter as cycle counts. The two timers advance only on cycles where the clocks-stable qualifier is high.

The write port is a plain strobe: every cycle with `wr_valid` high is a completed write. There is no back-pressure, so no ready signal is returned. The register contents leave the block on `cfg_o` for the converter datapath. Register i occupies bits [8i+7:8i].

Top module: `pwrseq_mode_sel`

## Requirements
- R1: While `rst_n` is low, the outputs are forced at once to these values: `mode_o`=00, `pdn_o`=1, `ready_o`=0, `fref_en_o`=0, and all of `cfg_o` zero. Writes presented during reset leave `cfg_o` unchanged.
- R2: After reset release the block is in selection mode (`mode_o`=00), with `pdn_o`=1 and `ready_o`=`fref_en_o`=0. Any write stores `wr_data` into register `wr_addr`, and the new value appears on `cfg_o` after that clock edge.
- R3: The window covers the first WIN_CYC clocks-stable edges after release, the last of these included. During it, a write of exactly 0x30 to address 5 sets `mode_o`=10 (register mode) after that edge. Writes of other values to address 5 do not select a mode.
- R4: If no qualifying write arrives, the WIN_CYC-th clocks-stable edge sets `mode_o`=01 (hardware mode) with `ready_o`=1 and `pdn_o`=0. Before that edge the block is still in selection mode.
- R5: `fref_en_o` is high exactly when `ready_o` is high.
- R6: In hardware mode, a write to address 5 with bit 5 (control-port enable) set moves the block to register mode after that edge. A write with bit 5 clear leaves it in hardware mode.
- R7: Register mode holds until reset. In register mode `pdn_o` equals bit 4 (power-down) of register 5.
- R8: In register mode `ready_o` rises after PU_CYC clocks-stable edges with register 5 bit 4 at 0. Setting bit 4 drops `ready_o` after that edge and restarts the delay.
- R9: While `clks_ok` is low, neither the selection window nor the power-up delay advances.
- R10: Asserting reset during the window and releasing it again restarts the window from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clks_ok | input | 1 | High when master and frame clocks are stable; gates both timers |
| wr_valid | input | 1 | Write strobe, one write per high cycle |
| wr_addr | input | AW | Register address |
| wr_data | input | DW | Register data |
| mode_o | output | 2 | 00 selecting, 01 hardware mode, 10 register mode |
| pdn_o | output | 1 | Power-down status |
| fref_en_o | output | 1 | Filter-reference enable |
| ready_o | output | 1 | Normal operation ready |
| cfg_o | output | NREG*DW | Flattened register contents |

## Verification
The mode decision is tried with several write patterns:
- An idle window, which tells apart expiry on the exact edge from expiry one edge early or late.
- A near-miss write to the control address with the wrong value.
- The magic write landing on the last edge of the window, which tells apart the window boundary from an off-by-one.
- A late enable write after fallback, sent both with and without the enable bit.

The power-up delay is timed once with stable clocks and once with a stall in the middle. The window is also run with a clock stall in the middle and with a reset during the window, which shows that gating and restart are honoured.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  typedef enum logic [1:0] {
    MODE_SEL = 2'b00,
    MODE_HW  = 2'b01,
    MODE_REG = 2'b10
  } mode_e;

  localparam int CTRL_ADDR = 5;
  localparam int CPEN_BIT  = 5;
  localparam int PDN_BIT   = 4;
  localparam logic [7:0] SEL_KEY = 8'h30;
endpackage

// File: rtl/pwrseq_regs.sv
module pwrseq_regs #(
  parameter int NREG = 8,
  parameter int DW   = 8,
  localparam int AW  = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      data_i,
  output logic [NREG*DW-1:0] q_o
);
  logic [DW-1:0] mem [NREG];

  // R1: defaults on reset; R2: store every accepted write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (we_i) begin
      mem[addr_i] <= data_i;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign q_o[g*DW +: DW] = mem[g];
  end
endmodule

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
  parameter int LIMIT = 10,
  localparam int CW   = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  output logic done_o
);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (clr_i)               cnt_q <= '0;
    else if (en_i && cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == LIM);
endmodule

// File: rtl/pwrseq_mode_sel.sv
module pwrseq_mode_sel
  import pwrseq_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000,
  parameter int WIN_MS = 10,
  parameter int PU_US  = 10,
  parameter int NREG   = 8,
  parameter int DW     = 8,
  localparam int AW    = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clks_ok,
  input  logic               wr_valid,
  input  logic [AW-1:0]      wr_addr,
  input  logic [DW-1:0]      wr_data,
  output logic [1:0]         mode_o,
  output logic               pdn_o,
  output logic               fref_en_o,
  output logic               ready_o,
  output logic [NREG*DW-1:0] cfg_o
);
  localparam int WIN_CYC = (CLK_HZ / 1000) * WIN_MS;
  localparam int PU_CYC  = (CLK_HZ / 1_000_000) * PU_US;
  localparam logic [AW-1:0] CTRL_A = AW'(CTRL_ADDR);

  mode_e         mode_q, mode_d;
  logic [DW-1:0] ctl;
  logic          pdn_bit, hit_ctl, key_hit, late_en;
  logic          win_en, win_done, pu_run, pu_done;

  pwrseq_regs #(.NREG(NREG), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(wr_valid),
    .addr_i(wr_addr), .data_i(wr_data), .q_o(cfg_o)
  );

  assign ctl     = cfg_o[CTRL_ADDR*DW +: DW];
  assign pdn_bit = ctl[PDN_BIT];
  assign hit_ctl = wr_valid && (wr_addr == CTRL_A);
  assign key_hit = hit_ctl && (wr_data == DW'(SEL_KEY));
  assign late_en = hit_ctl && wr_data[CPEN_BIT];

  // R3/R4/R9/R10: window timer counts stable-clock edges while selecting
  assign win_en = (mode_q == MODE_SEL) && clks_ok;
  pwrseq_timer #(.LIMIT(WIN_CYC - 1)) u_win (
    .clk(clk), .rst_n(rst_n), .clr_i(1'b0), .en_i(win_en), .done_o(win_done)
  );

  // R8/R9: power-up delay runs while in register mode with power-down clear
  assign pu_run = (mode_q == MODE_REG) && !pdn_bit;
  pwrseq_timer #(.LIMIT(PU_CYC)) u_pu (
    .clk(clk), .rst_n(rst_n), .clr_i(!pu_run), .en_i(clks_ok), .done_o(pu_done)
  );

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_SEL: begin
        if (key_hit)                 mode_d = MODE_REG;
        else if (win_en && win_done) mode_d = MODE_HW;
      end
      MODE_HW:  if (late_en) mode_d = MODE_REG;
      default:  mode_d = MODE_REG;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_SEL;
    else        mode_q <= mode_d;
  end

  assign mode_o    = mode_q;
  assign ready_o   = (mode_q == MODE_HW) || (pu_run && pu_done);
  assign fref_en_o = ready_o;
  assign pdn_o     = (mode_q == MODE_SEL) ? 1'b1 :
                     (mode_q == MODE_HW)  ? 1'b0 : pdn_bit;
endmodule

// File: rtl/pwrseq_mode_sel_chk.sv
module pwrseq_mode_sel_chk #(
  parameter int NREG = 8,
  parameter int DW   = 8,
  localparam int AW  = $clog2(NREG)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_valid,
  input logic [AW-1:0]      wr_addr,
  input logic [DW-1:0]      wr_data,
  input logic [1:0]         mode_o,
  input logic               pdn_o,
  input logic               fref_en_o,
  input logic               ready_o,
  input logic [NREG*DW-1:0] cfg_o
);
  localparam logic [AW-1:0] CA = AW'(5);
  logic ctl_pdn;
  assign ctl_pdn = cfg_o[5*DW + 4];

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_state: assert (mode_o == 2'b00 && pdn_o && !ready_o &&
                                !fref_en_o && cfg_o == '0)
        else $error("reset state violated");
    end
  end

  a_r2_select_lowpower: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b00) |-> (pdn_o && !ready_o));

  a_r3_key_selects: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b00 && wr_valid && wr_addr == CA && wr_data == DW'(8'h30))
    |=> (mode_o == 2'b10));

  a_r4_hw_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b01) |-> (ready_o && !pdn_o));

  a_r5_fref_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    fref_en_o |-> ready_o);

  a_r6_late_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b01 && wr_valid && wr_addr == CA && wr_data[5])
    |=> (mode_o == 2'b10));

  a_r7_reg_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b10) |=> (mode_o == 2'b10));

  a_r8_pdn_blocks_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b10 && ctl_pdn) |-> (!ready_o && pdn_o));
endmodule

bind pwrseq_mode_sel pwrseq_mode_sel_chk #(.NREG(NREG), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
  .wr_data(wr_data), .mode_o(mode_o), .pdn_o(pdn_o), .fref_en_o(fref_en_o),
  .ready_o(ready_o), .cfg_o(cfg_o)
);

// File: tb/pwrseq_mode_sel_bench.sv
module pwrseq_mode_sel_bench;
  localparam int CLK_HZ = 1_000_000;
  localparam int WIN    = (CLK_HZ / 1000) * 10;
  localparam int PU     = (CLK_HZ / 1_000_000) * 10;
  localparam int NREG   = 8;
  localparam int DW     = 8;
  localparam int AW     = $clog2(NREG);

  logic clk = 0, rst_n = 0, clks_ok = 1, wr_valid = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [1:0] mode_o;
  logic pdn_o, fref_en_o, ready_o;
  logic [NREG*DW-1:0] cfg_o;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  typedef struct {
    string tag;
    logic [1:0] md;
    logic pdn, rdy, fr;
    int idx;
    logic [7:0] val;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  pwrseq_mode_sel #(.CLK_HZ(CLK_HZ), .WIN_MS(10), .PU_US(10), .NREG(NREG), .DW(DW))
  u_pwrseq_mode_sel (
    .clk(clk), .rst_n(rst_n), .clks_ok(clks_ok), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .mode_o(mode_o), .pdn_o(pdn_o),
    .fref_en_o(fref_en_o), .ready_o(ready_o), .cfg_o(cfg_o)
  );

  // monitor: pops expectations and compares against the ports
  initial begin
    forever begin
      exp_t it;
      logic [7:0] got_v;
      wait (sb.size() != 0);
      it = sb.pop_front();
      got_v = cfg_o[it.idx*8 +: 8];
      n_cmp++;
      if (mode_o !== it.md || pdn_o !== it.pdn || ready_o !== it.rdy ||
          fref_en_o !== it.fr || got_v !== it.val) begin
        n_bad++;
        $display("FAIL %s: mode/pdn/rdy/fref/cfg[%0d] got %b/%b/%b/%b/%h exp %b/%b/%b/%b/%h",
                 it.tag, it.idx, mode_o, pdn_o, ready_o, fref_en_o, got_v,
                 it.md, it.pdn, it.rdy, it.fr, it.val);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    wr_addr = AW'(a); wr_data = DW'(d); wr_valid = 1;
    step(1);
    wr_valid = 0;
  endtask

  task automatic expect_out(string tag, logic [1:0] md, logic pdn, logic rdy,
                            logic fr, int idx, logic [7:0] val);
    exp_t it;
    it.tag = tag; it.md = md; it.pdn = pdn; it.rdy = rdy; it.fr = fr;
    it.idx = idx; it.val = val;
    sb.push_back(it);
    wait (sb.size() == 0);
    #1;
  endtask

  task automatic pulse_reset();
    rst_n = 0; step(2); rst_n = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, got hung exp done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    step(1);
    wr(2, 'hAA);                                     // ignored in reset
    expect_out("R1 reset state", 2'b00, 1, 0, 0, 2, 8'h00);
    rst_n = 1;                                       // edge count e=0
    expect_out("R2 after release", 2'b00, 1, 0, 0, 5, 8'h00);
    wr(2, 'h5A);                                     // e=1
    expect_out("R2 write stored", 2'b00, 1, 0, 0, 2, 8'h5A);
    wr(5, 'h20);                                     // e=2, not the key
    expect_out("R3 non-key write", 2'b00, 1, 0, 0, 5, 8'h20);
    step(WIN - 3);                                   // e=WIN-1
    expect_out("R4 before expiry", 2'b00, 1, 0, 0, 5, 8'h20);
    step(1);                                         // e=WIN
    expect_out("R4 R5 hw mode", 2'b01, 0, 1, 1, 5, 8'h20);
    wr(5, 'h10);
    expect_out("R6 no enable bit", 2'b01, 0, 1, 1, 5, 8'h10);
    wr(5, 'h30);
    expect_out("R6 R7 late enable", 2'b10, 1, 0, 0, 5, 8'h30);
    wr(5, 'h20);
    expect_out("R8 pdn cleared", 2'b10, 0, 0, 0, 5, 8'h20);
    step(PU - 1);
    expect_out("R8 delay pending", 2'b10, 0, 0, 0, 5, 8'h20);
    step(1);
    expect_out("R8 R5 ready", 2'b10, 0, 1, 1, 5, 8'h20);
    wr(5, 'h30);
    expect_out("R8 pdn set", 2'b10, 1, 0, 0, 5, 8'h30);
    wr(5, 'h00);
    expect_out("R7 sticky", 2'b10, 0, 0, 0, 5, 8'h00);
    step(3);
    clks_ok = 0;
    step(PU + 5);
    clks_ok = 1;
    step(PU - 4);
    expect_out("R9 delay paused", 2'b10, 0, 0, 0, 5, 8'h00);
    step(1);
    expect_out("R9 delay resumes", 2'b10, 0, 1, 1, 5, 8'h00);

    pulse_reset();
    step(WIN - 1);
    wr(5, 'h30);                                     // on edge WIN
    expect_out("R3 key on last edge", 2'b10, 1, 0, 0, 5, 8'h30);

    pulse_reset();
    step(5);
    rst_n = 0; step(2);
    expect_out("R10 in reset", 2'b00, 1, 0, 0, 5, 8'h00);
    rst_n = 1;
    step(WIN - 1);
    expect_out("R10 window restarted", 2'b00, 1, 0, 0, 5, 8'h00);
    step(1);
    expect_out("R10 expiry", 2'b01, 0, 1, 1, 5, 8'h00);

    pulse_reset();
    step(100);
    clks_ok = 0; step(50); clks_ok = 1;
    step(WIN - 101);
    expect_out("R9 window paused", 2'b00, 1, 0, 0, 5, 8'h00);
    step(1);
    expect_out("R9 window expiry", 2'b01, 0, 1, 1, 5, 8'h00);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule